// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a compact integer processor that completes one 32-bit fixed-length instruction on every clock edge. It supports a small subset of a three-operand load/store instruction set. The design contains a program counter, a 32-entry register file of 32-bit registers, an arithmetic unit, and two word-organised internal memories: one holds the program and the other holds data. Arithmetic works only between registers or between a register and a constant. Only the load and store instructions access the data memory.

A host or testbench fills the memories through a load port. It keeps the core in reset while it does so. When reset is released, the core starts at address zero and runs. A debug read port returns any register asynchronously, so the results can be checked. The current program counter is also visible at the ports.

Top module: `scCore`

## Requirements
- R1: While `rstN` is low, `pcOut` is 0 and every register reads 0 through the debug port. Execution starts at address 0 after release.
- R2: Register 0 always reads 0, and any write that targets it is discarded.
- R3: Instruction fields, from bit 31 down, are op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. The immediate is [15:0] and the jump target is [25:0]. With op 0, funct 32 writes rs+rt to rd, funct 34 writes rs−rt and funct 36 writes rs AND rt. Add and subtract wrap modulo 2^32.
- R4: With op 0, funct 42 writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise. Op 10 compares rs with the sign-extended immediate and writes the result to rt.
- R5: Op 8 writes rs plus the sign-extended immediate to rt.
- R6: Op 15 writes the immediate shifted left by 16 bits, with zeros below, to rt.
- R7: Op 35 loads the data word at byte address rs+sext(imm) into rt. Op 43 stores rt at that address. The data memory word index is address bits [9:2], so addresses wrap every 1024 bytes.
- R8: Op 4 (branch if rs equals rt) and op 5 (branch if they differ) go to PC+4+sext(imm)·4 when the condition holds, and to PC+4 otherwise.
- R9: Op 2 jumps to {PC+4 bits [31:28], target, 00}. Op 3 does the same and also writes PC+4 into register 31.
- R10: With op 0, funct 8 sets the next PC to the value in rs.
- R11: Any other op, and any other funct under op 0, changes no register and no memory word, and only advances the PC by 4.
- R12: One instruction completes per rising clock edge. Every instruction that is not a branch or a jump advances the PC by exactly 4.
- R13: When `loadEn` is high, a rising edge writes `loadData` into the word at index `loadAddr`. `loadSel` 0 selects the instruction memory and `loadSel` 1 selects the data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset; clears PC and registers |
| loadEn | input | 1 | Memory preload write strobe |
| loadSel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| loadAddr | input | 8 | Preload word index |
| loadData | input | 32 | Preload word |
| dbgRegSel | input | 5 | Register number for debug read |
| dbgRegData | output | 32 | Value of the selected register |
| pcOut | output | 32 | Current program counter (byte address) |

## Verification
The bench builds the core with its default 256-word instruction and data memories. At that size, the 10-bit wrap of the data address is easy to reach: a load at byte 1020 reads the last word, and a store at byte 1024 lands on word 0. Directed programs check each arithmetic, compare, memory, branch and jump operation. A taken branch, a not-taken branch, a backward loop, and a call followed by a register return show the program counter at exact cycles. Words with undefined opcodes and undefined function codes show that they leave the registers and data untouched.

// File: rtl/scPkg.sv
package scPkg;

  localparam int XLEN    = 32;
  localparam int NUM_REG = 32;
  localparam int REG_AW  = $clog2(NUM_REG);
  localparam int LINK_REG = 31;

  // primary opcodes (bits 31:26)
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_ADDI    = 6'd8;
  localparam logic [5:0] OP_SLTI    = 6'd10;
  localparam logic [5:0] OP_LUI     = 6'd15;
  localparam logic [5:0] OP_LW      = 6'd35;
  localparam logic [5:0] OP_SW      = 6'd43;

  // function codes under OP_SPECIAL (bits 5:0)
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_SLT} aluOp_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dstSel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK, WB_UPPER} wbSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    regWrite;
    dstSel_e dstSel;
    wbSel_e  wbSel;
    logic    aluImm;
    aluOp_e  aluOp;
    logic    memWrite;
    logic    brEq;
    logic    brNe;
    logic    jump;
    logic    jumpReg;
  } ctrlStrobes_t;

endpackage

// File: rtl/scAlu.sv
module scAlu
  import scPkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluOp_e       op,
  output logic [W-1:0] result
);

  always_comb begin
    unique case (op)
      ALU_ADD: result = opA + opB;                     // R3/R5: wraps
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))}; // R4
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/scRegFile.sv
module scRegFile #(
  parameter int REGS  = 32,
  parameter int W     = 32,
  parameter int NREAD = 3,
  localparam int AW   = $clog2(REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [AW-1:0]              wrIdx,
  input  logic [W-1:0]               wrData,
  input  logic [NREAD-1:0][AW-1:0]   rdIdx,
  output logic [NREAD-1:0][W-1:0]    rdData
);

  // storage for registers 1..REGS-1 only; register 0 has no flops (R2)
  logic [W-1:0] regQ [1:REGS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 1; i < REGS; i++) regQ[i] <= '0;   // R1
    end else if (wrEn && (wrIdx != '0)) begin
      regQ[wrIdx] <= wrData;
    end
  end

  for (genvar g = 0; g < NREAD; g++) begin : gRead
    assign rdData[g] = (rdIdx[g] == '0) ? '0 : regQ[rdIdx[g]];
  end

endmodule

// File: rtl/scControl.sv
module scControl
  import scPkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrlStrobes_t    ctrl
);

  logic [5:0] opField;
  logic [5:0] fnField;
  logic       unusedMidBits;

  assign opField       = instr[31:26];
  assign fnField       = instr[5:0];
  assign unusedMidBits = ^instr[25:6];

  always_comb begin
    ctrl = '0;   // R11: anything undecoded leaves every strobe low
    unique case (opField)
      OP_SPECIAL: begin
        unique case (fnField)
          FN_ADD: begin ctrl.regWrite = 1'b1; ctrl.dstSel = DST_RD; ctrl.aluOp = ALU_ADD; end
          FN_SUB: begin ctrl.regWrite = 1'b1; ctrl.dstSel = DST_RD; ctrl.aluOp = ALU_SUB; end
          FN_AND: begin ctrl.regWrite = 1'b1; ctrl.dstSel = DST_RD; ctrl.aluOp = ALU_AND; end
          FN_SLT: begin ctrl.regWrite = 1'b1; ctrl.dstSel = DST_RD; ctrl.aluOp = ALU_SLT; end
          FN_JR:  ctrl.jumpReg = 1'b1;                                    // R10
          default: ;
        endcase
      end
      OP_ADDI: begin ctrl.regWrite = 1'b1; ctrl.aluImm = 1'b1; ctrl.aluOp = ALU_ADD; end
      OP_SLTI: begin ctrl.regWrite = 1'b1; ctrl.aluImm = 1'b1; ctrl.aluOp = ALU_SLT; end
      OP_LUI:  begin ctrl.regWrite = 1'b1; ctrl.wbSel = WB_UPPER; end      // R6
      OP_LW: begin
        ctrl.regWrite = 1'b1; ctrl.aluImm = 1'b1; ctrl.aluOp = ALU_ADD; ctrl.wbSel = WB_MEM;
      end
      OP_SW:   begin ctrl.memWrite = 1'b1; ctrl.aluImm = 1'b1; ctrl.aluOp = ALU_ADD; end
      OP_BEQ:  ctrl.brEq = 1'b1;                                           // R8
      OP_BNE:  ctrl.brNe = 1'b1;
      OP_J:    ctrl.jump = 1'b1;                                           // R9
      OP_JAL: begin
        ctrl.jump = 1'b1; ctrl.regWrite = 1'b1; ctrl.dstSel = DST_LINK; ctrl.wbSel = WB_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scDatapath.sv
module scDatapath
  import scPkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  parameter int LOAD_AW    = 8,
  localparam int IMEM_AW   = $clog2(IMEM_WORDS),
  localparam int DMEM_AW   = $clog2(DMEM_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        ctrl,
  output logic [XLEN-1:0]     instr,
  input  logic                loadEn,
  input  logic                loadSel,
  input  logic [LOAD_AW-1:0]  loadAddr,
  input  logic [XLEN-1:0]     loadData,
  input  logic [REG_AW-1:0]   dbgRegSel,
  output logic [XLEN-1:0]     dbgRegData,
  output logic [XLEN-1:0]     pcOut
);

  localparam int NREAD = 3;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pcQ, pcPlus4, brTarget, jmpTarget, nextPc;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic [15:0]     immField;
  logic [XLEN-1:0] immSext, rsVal, rtVal, aluB, aluY, memRd, wbData;
  logic            operandsEq, brTaken;

  logic [NREAD-1:0][REG_AW-1:0] rfRdIdx;
  logic [NREAD-1:0][XLEN-1:0]   rfRdData;

  // fetch: word index from PC bits [IMEM_AW+1:2]
  assign instr    = imem[pcQ[IMEM_AW+1:2]];
  assign rsIdx    = instr[25:21];
  assign rtIdx    = instr[20:16];
  assign rdIdx    = instr[15:11];
  assign immField = instr[15:0];
  assign immSext  = {{(XLEN-16){immField[15]}}, immField};

  always_comb begin
    unique case (ctrl.dstSel)
      DST_RD:   wrIdx = rdIdx;
      DST_LINK: wrIdx = REG_AW'(LINK_REG);
      default:  wrIdx = rtIdx;
    endcase
  end

  assign rfRdIdx = {dbgRegSel, rtIdx, rsIdx};
  assign rsVal      = rfRdData[0];
  assign rtVal      = rfRdData[1];
  assign dbgRegData = rfRdData[2];

  scRegFile #(.REGS(NUM_REG), .W(XLEN), .NREAD(NREAD)) uRegFile (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (ctrl.regWrite),
    .wrIdx  (wrIdx),
    .wrData (wbData),
    .rdIdx  (rfRdIdx),
    .rdData (rfRdData)
  );

  assign aluB = ctrl.aluImm ? immSext : rtVal;

  scAlu #(.W(XLEN)) uAlu (
    .opA    (rsVal),
    .opB    (aluB),
    .op     (ctrl.aluOp),
    .result (aluY)
  );

  // R7: data word index from address bits [DMEM_AW+1:2]
  assign memRd = dmem[aluY[DMEM_AW+1:2]];

  always_comb begin
    unique case (ctrl.wbSel)
      WB_MEM:   wbData = memRd;
      WB_LINK:  wbData = pcPlus4;
      WB_UPPER: wbData = {immField, {(XLEN-16){1'b0}}};
      default:  wbData = aluY;
    endcase
  end

  // next PC selection
  assign pcPlus4    = pcQ + XLEN'(4);
  assign brTarget   = pcPlus4 + {immSext[XLEN-3:0], 2'b00};
  assign jmpTarget  = {pcPlus4[XLEN-1:28], instr[25:0], 2'b00};
  assign operandsEq = (rsVal == rtVal);
  assign brTaken    = (ctrl.brEq && operandsEq) || (ctrl.brNe && !operandsEq);

  always_comb begin
    if (ctrl.jumpReg)   nextPc = rsVal;
    else if (ctrl.jump) nextPc = jmpTarget;
    else if (brTaken)   nextPc = brTarget;
    else                nextPc = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcQ <= '0;
    else       pcQ <= nextPc;
  end

  assign pcOut = pcQ;

  // R13: preload writes
  always_ff @(posedge clk) begin
    if (loadEn && !loadSel) imem[loadAddr[IMEM_AW-1:0]] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadSel)           dmem[loadAddr[DMEM_AW-1:0]] <= loadData;
    else if (rstN && ctrl.memWrite)  dmem[aluY[DMEM_AW+1:2]]     <= rtVal;
  end

endmodule

// File: rtl/scCore.sv
module scCore
  import scPkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  localparam int IMEM_AW   = $clog2(IMEM_WORDS),
  localparam int DMEM_AW   = $clog2(DMEM_WORDS),
  localparam int LOAD_AW   = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               loadSel,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]    loadData,
  input  logic [REG_AW-1:0]  dbgRegSel,
  output logic [XLEN-1:0]    dbgRegData,
  output logic [XLEN-1:0]    pcOut
);

  logic [XLEN-1:0] instrW;
  ctrlStrobes_t    ctrlW;

  scControl uControl (
    .instr (instrW),
    .ctrl  (ctrlW)
  );

  scDatapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS),
    .LOAD_AW    (LOAD_AW)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlW),
    .instr      (instrW),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .pcOut      (pcOut)
  );

endmodule

// File: rtl/scCoreChecker.sv
module scCoreChecker
  import scPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [XLEN-1:0]   pcOut,
  input logic [XLEN-1:0]   instr,
  input ctrlStrobes_t      ctrl,
  input logic [REG_AW-1:0] dbgRegSel,
  input logic [XLEN-1:0]   dbgRegData
);

  logic [XLEN-1:0] seqPc;
  logic            knownOp;
  logic            anyFlow;

  assign seqPc   = pcOut + XLEN'(4);
  assign anyFlow = ctrl.brEq || ctrl.brNe || ctrl.jump || ctrl.jumpReg;

  always_comb begin
    unique case (instr[31:26])
      OP_SPECIAL: knownOp = (instr[5:0] == FN_ADD) || (instr[5:0] == FN_SUB) ||
                            (instr[5:0] == FN_AND) || (instr[5:0] == FN_SLT) ||
                            (instr[5:0] == FN_JR);
      OP_J, OP_JAL, OP_BEQ, OP_BNE, OP_ADDI, OP_SLTI, OP_LUI, OP_LW, OP_SW: knownOp = 1'b1;
      default: knownOp = 1'b0;
    endcase
  end

  // R1: PC held at zero in reset
  assert_reset_pc_R1: assert property (@(posedge clk) !rstN |-> pcOut == '0);

  // R2: register 0 reads zero
  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dbgRegSel == '0) |-> (dbgRegData == '0));

  // R8: at most one control-flow strobe per instruction
  assert_flow_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.brEq, ctrl.brNe, ctrl.jump, ctrl.jumpReg}));

  // R9: jump lands on the composed target
  assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.jump |=> pcOut == {$past(seqPc[XLEN-1:28]), $past(instr[25:0]), 2'b00});

  // R9: link register holds the return address after a call
  assert_link_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.jump && ctrl.regWrite) |=> (dbgRegSel != REG_AW'(LINK_REG)) || (dbgRegData == $past(seqPc)));

  // R11: undefined encodings raise no strobe
  assert_undef_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !knownOp |-> !(ctrl.regWrite || ctrl.memWrite || anyFlow));

  // R12: sequential instructions advance by four
  assert_pc_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    !anyFlow |=> pcOut == $past(seqPc));

endmodule

bind scCore scCoreChecker uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .pcOut      (pcOut),
  .instr      (instrW),
  .ctrl       (ctrlW),
  .dbgRegSel  (dbgRegSel),
  .dbgRegData (dbgRegData)
);

// File: tb/scCore_tb_top.sv
module scCore_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadSel = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegData;
  logic [31:0] pcOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  scCore dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .dbgRegSel  (dbgRegSel),
    .dbgRegData (dbgRegData),
    .pcOut      (pcOut)
  );

  // encoders
  function automatic logic [31:0] encR(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] encI(int op, int rs, int rt, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] encJ(int op, int tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkReg(string tag, int idx, logic [31:0] exp);
    dbgRegSel = idx[4:0];
    #1;
    check(tag, dbgRegData, exp);
  endtask

  task automatic poke(bit sel, int addr, logic [31:0] w);
    @(negedge clk);
    loadEn = 1'b1; loadSel = sel; loadAddr = addr[7:0]; loadData = w;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic holdReset();
    @(negedge clk);
    rstN = 1'b0;
  endtask

  task automatic release_run();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 pc in reset", pcOut, 32'h0);
    checkReg("R1 r1 in reset", 1, 32'h0);
    checkReg("R1 r31 in reset", 31, 32'h0);
  endtask

  task automatic testArith();
    holdReset();
    poke(0, 0, encI(8, 0, 1, 5));
    poke(0, 1, encI(8, 0, 2, -3));
    poke(0, 2, encR(1, 2, 3, 32));
    poke(0, 3, encR(2, 1, 4, 34));
    poke(0, 4, encR(1, 2, 5, 36));
    poke(0, 5, encI(15, 0, 6, 'h8000));
    poke(0, 6, encR(6, 1, 7, 34));
    poke(0, 7, encI(8, 0, 0, 7));
    poke(0, 8, encR(6, 6, 8, 32));
    poke(0, 9, encJ(2, 9));
    release_run();
    runCycles(15);
    checkReg("R5 addi positive", 1, 32'd5);
    checkReg("R5 addi negative", 2, 32'hFFFF_FFFD);
    checkReg("R3 add", 3, 32'd2);
    checkReg("R3 sub", 4, 32'hFFFF_FFF8);
    checkReg("R3 and", 5, 32'd5);
    checkReg("R6 lui", 6, 32'h8000_0000);
    checkReg("R3 sub wrap", 7, 32'h7FFF_FFFB);
    checkReg("R2 write to r0 dropped", 0, 32'h0);
    checkReg("R3 add wrap", 8, 32'h0);
    check("R9 halt loop pc", pcOut, 32'd36);
    // R1: reset clears state after a run
    holdReset();
    #1;
    check("R1 pc after re-reset", pcOut, 32'h0);
    checkReg("R1 r3 after re-reset", 3, 32'h0);
    checkReg("R1 r6 after re-reset", 6, 32'h0);
  endtask

  task automatic testCompare();
    holdReset();
    poke(0, 0, encI(8, 0, 1, -1));
    poke(0, 1, encI(8, 0, 2, 1));
    poke(0, 2, encR(1, 2, 3, 42));
    poke(0, 3, encR(2, 1, 4, 42));
    poke(0, 4, encI(10, 1, 5, 0));
    poke(0, 5, encI(10, 2, 6, -5));
    poke(0, 6, encI(10, 2, 7, 2));
    poke(0, 7, encR(2, 2, 8, 42));
    poke(0, 8, encJ(2, 8));
    release_run();
    runCycles(12);
    checkReg("R4 slt -1<1", 3, 32'd1);
    checkReg("R4 slt 1<-1", 4, 32'd0);
    checkReg("R4 slti -1<0", 5, 32'd1);
    checkReg("R4 slti 1<-5", 6, 32'd0);
    checkReg("R4 slti 1<2", 7, 32'd1);
    checkReg("R4 slt equal", 8, 32'd0);
  endtask

  task automatic testMemory();
    holdReset();
    poke(1, 4,   32'hCAFE_F00D);
    poke(1, 255, 32'h1234_5678);
    poke(0, 0, encI(8, 0, 1, 8));
    poke(0, 1, encI(35, 1, 2, 8));
    poke(0, 2, encI(43, 1, 2, -4));
    poke(0, 3, encI(35, 0, 4, 4));
    poke(0, 4, encI(35, 0, 5, 1020));
    poke(0, 5, encI(43, 0, 5, 1024));
    poke(0, 6, encI(35, 0, 6, 0));
    poke(0, 7, encJ(2, 7));
    release_run();
    runCycles(12);
    checkReg("R13 R7 lw preloaded word", 2, 32'hCAFE_F00D);
    checkReg("R7 sw negative offset then lw", 4, 32'hCAFE_F00D);
    checkReg("R7 lw last word", 5, 32'h1234_5678);
    checkReg("R7 sw address wrap", 6, 32'h1234_5678);
  endtask

  task automatic testBranch();
    holdReset();
    poke(0, 0,  encI(8, 0, 1, 1));
    poke(0, 1,  encI(8, 0, 2, 1));
    poke(0, 2,  encI(4, 1, 2, 2));
    poke(0, 3,  encI(8, 0, 3, 99));
    poke(0, 4,  encI(8, 0, 4, 99));
    poke(0, 5,  encI(5, 1, 2, 1));
    poke(0, 6,  encI(8, 0, 5, 7));
    poke(0, 7,  encI(8, 6, 6, 1));
    poke(0, 8,  encI(10, 6, 7, 3));
    poke(0, 9,  encI(5, 7, 0, -3));
    poke(0, 10, encJ(2, 10));
    release_run();
    runCycles(1);
    check("R12 pc after first instr", pcOut, 32'd4);
    runCycles(1);
    check("R12 pc after second instr", pcOut, 32'd8);
    runCycles(1);
    check("R8 beq taken target", pcOut, 32'd20);
    runCycles(1);
    check("R8 bne not taken", pcOut, 32'd24);
    runCycles(20);
    check("R8 loop exit pc", pcOut, 32'd40);
    checkReg("R8 skipped r3", 3, 32'd0);
    checkReg("R8 skipped r4", 4, 32'd0);
    checkReg("R8 fallthrough r5", 5, 32'd7);
    checkReg("R8 backward loop count", 6, 32'd3);
  endtask

  task automatic testJump();
    holdReset();
    poke(0, 0, encJ(3, 4));
    poke(0, 1, encI(8, 0, 1, 11));
    poke(0, 2, encJ(2, 7));
    poke(0, 3, encI(8, 0, 4, 99));
    poke(0, 4, encI(8, 0, 2, 22));
    poke(0, 5, encR(31, 0, 0, 8));
    poke(0, 6, encI(8, 0, 4, 99));
    poke(0, 7, encI(8, 0, 3, 33));
    poke(0, 8, encJ(2, 8));
    release_run();
    runCycles(1);
    check("R9 jal target", pcOut, 32'd16);
    checkReg("R9 jal link", 31, 32'd4);
    runCycles(2);
    check("R10 jr to link", pcOut, 32'd4);
    runCycles(2);
    check("R9 j target", pcOut, 32'd28);
    runCycles(10);
    check("R9 final pc", pcOut, 32'd32);
    checkReg("R10 return path r1", 1, 32'd11);
    checkReg("R9 callee r2", 2, 32'd22);
    checkReg("R9 after jump r3", 3, 32'd33);
    checkReg("R9 skipped r4", 4, 32'd0);
  endtask

  task automatic testUndefined();
    holdReset();
    poke(1, 0, 32'h0000_A5A5);
    poke(0, 0, encI(8, 0, 1, 5));
    poke(0, 1, 32'hFFFF_FFFF);
    poke(0, 2, encR(1, 1, 2, 1));
    poke(0, 3, encI(9, 0, 3, 7));
    poke(0, 4, encI(35, 0, 4, 0));
    poke(0, 5, encJ(2, 5));
    release_run();
    runCycles(2);
    check("R11 pc after undefined op", pcOut, 32'd8);
    runCycles(1);
    check("R11 pc after undefined funct", pcOut, 32'd12);
    runCycles(8);
    checkReg("R11 r1 intact", 1, 32'd5);
    checkReg("R11 undefined funct no write", 2, 32'd0);
    checkReg("R11 undefined op no write", 3, 32'd0);
    checkReg("R11 all-ones no write r31", 31, 32'd0);
    checkReg("R11 data word untouched", 4, 32'h0000_A5A5);
  endtask

  initial begin
    #1 rstN = 1'b0;
    testReset();
    testArith();
    testCompare();
    testMemory();
    testBranch();
    testJump();
    testUndefined();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule